// File: doc/BRIEF.md
# Sample Latency Line with Event Capture Buffer

This block takes a single channel of 10-bit converter samples, one per clock, and holds each one back by a fixed 128 clocks in a circular dual-port store. At 40 MS/s, 128 clocks is 3.2 µs. An upstream trigger decision arrives as a gate on `acceptIn`, which lines up with the delayed stream. While the gate is high, the delayed samples are packed into a small multi-event buffer together with the timestamp of the first gated clock.

Each gate period that finds a free slot becomes one event of the form header, samples, trailer. A downstream consumer drains the events in arrival order with a valid/ready handshake. An event is offered only after its gate has closed. If every slot is taken when a gate opens, that gate period is dropped and a saturating overflow counter counts it.

Top module: `latency_event_buffer`

## Requirements
- R1: A sample presented on `sampleIn` at clock edge k is the one stored for a gate that is high at edge k+128. The latency is exactly 128 edges.
- R2: Only delayed samples from edges where `acceptIn` is high enter an event, and they are stored in the order they occurred.
- R3: The first word of every event is a header. Its bits [17:16] are 2'b01 and its bits [15:0] hold `tsIn` as sampled at the first gated edge.
- R4: Each sample word has bits [17:16] = 2'b10 and the sample zero-extended in bits [15:0]. The last word of every event has bits [17:16] = 2'b11 and the stored sample count in bits [15:0]. `outLast` is high exactly on that last word.
- R5: An event stores at most 14 samples. Later samples of a longer gate period are dropped and the count reads 14.
- R6: `outValid` stays low while the only pending event is still being captured. It rises on the edge at which the gate is first seen low.
- R7: Up to four complete events are held. `bufFull` is high exactly while four events are stored.
- R8: A gate period that opens while the buffer is full is discarded whole. `ovfCount` rises by one, saturating at 255, and the stored events are unchanged.
- R9: A word is consumed only on an edge with `outValid` and `readyIn` both high. While it is not consumed, `outData` holds its value. Events leave in the order they were captured.
- R10: After reset `outValid`, `outLast` and `bufFull` are low and `ovfCount` is zero.
- R11: A new event can be captured while an earlier event is being read out, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 10 | Converter sample, one per clock |
| acceptIn | input | 1 | Gate aligned with the delayed stream |
| tsIn | input | 16 | Free-running timestamp |
| readyIn | input | 1 | Consumer can take a word |
| outData | output | 18 | Event word: 2-bit tag above a 16-bit payload |
| outValid | output | 1 | A complete event word is offered |
| outLast | output | 1 | Offered word is the event trailer |
| bufFull | output | 1 | All four event slots are occupied |
| ovfCount | output | 8 | Number of discarded gate periods, saturating |

## Verification
The hardest case to reach is a gate period that opens while an earlier event is only partly drained. In that case the write slot and the read slot move at once, and the occupancy count can rise and fall on the same edge. The bench forks a gated capture against a stalling readout of the previous event, so both sides advance together. It also fills all four slots and then offers two more gate periods, to show that they are dropped whole. Gate lengths are swept from 1 to 16, across the 14-sample limit, and a sample pattern that never repeats makes any latency off by one edge show up.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  parameter int SAMPLE_W = 10;   // converter resolution, must not exceed TS_W
  parameter int TS_W     = 16;
  parameter int DELAY    = 128;  // latency in clocks
  parameter int SLOTS    = 4;
  parameter int MAX_SAMP = 14;
  parameter int OVF_W    = 8;

  localparam int SLOT_WORDS = MAX_SAMP + 2;
  localparam int IDX_W      = $clog2(SLOT_WORDS);
  localparam int SLOT_AW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W      = $clog2(MAX_SAMP + 1);
  localparam int WORD_W     = TS_W + 2;
  localparam int RING       = DELAY - 1;  // one more stage is the output register
  localparam int RING_AW    = $clog2(RING);
  localparam int SMP_DEPTH  = SLOTS * MAX_SAMP;
  localparam int SMP_AW     = $clog2(SMP_DEPTH);

  localparam logic [1:0] TAG_HDR = 2'b01;
  localparam logic [1:0] TAG_SMP = 2'b10;
  localparam logic [1:0] TAG_TRL = 2'b11;

  typedef struct packed {
    logic               hdrEn;
    logic               smpEn;
    logic               trlEn;
    logic [SLOT_AW-1:0] wrSlot;
    logic [CNT_W-1:0]   wrIdx;
    logic [CNT_W-1:0]   trlCount;
    logic [SLOT_AW-1:0] rdSlot;
    logic [IDX_W-1:0]   rdIdx;
  } strobe_t;
endpackage

// File: rtl/lbuf_dpath.sv
module lbuf_dpath
  import lbuf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [TS_W-1:0]     tsIn,
  input  strobe_t             stb,
  output logic [CNT_W-1:0]    rdLen,
  output logic [WORD_W-1:0]   outData
);
  // circular latency store: read-before-write at the same address
  logic [SAMPLE_W-1:0] ring [RING];
  logic [RING_AW-1:0]  ringPtr;
  logic [SAMPLE_W-1:0] dlySample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ringPtr <= '0;
    else if (ringPtr == RING_AW'(RING - 1)) ringPtr <= '0;
    else ringPtr <= ringPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    ring[ringPtr] <= sampleIn;
    dlySample     <= ring[ringPtr];
  end

  // event storage: per-slot header and count, shared sample array
  logic [SAMPLE_W-1:0] smpMem [SMP_DEPTH];
  logic [TS_W-1:0]     tsReg  [SLOTS];
  logic [CNT_W-1:0]    cntReg [SLOTS];
  logic [SMP_AW-1:0]   wrAddr, rdAddr;
  logic [IDX_W-1:0]    trlIdx;

  assign wrAddr = SMP_AW'(int'(stb.wrSlot) * MAX_SAMP + int'(stb.wrIdx));
  assign rdAddr = SMP_AW'(int'(stb.rdSlot) * MAX_SAMP + int'(stb.rdIdx) - 1);

  always_ff @(posedge clk) begin
    if (stb.hdrEn) tsReg[stb.wrSlot]  <= tsIn;
    if (stb.smpEn) smpMem[wrAddr]     <= dlySample;
    if (stb.trlEn) cntReg[stb.wrSlot] <= stb.trlCount;
  end

  assign rdLen  = cntReg[stb.rdSlot];
  assign trlIdx = IDX_W'(rdLen) + IDX_W'(1);

  always_comb begin
    if (stb.rdIdx == '0)         outData = {TAG_HDR, tsReg[stb.rdSlot]};
    else if (stb.rdIdx == trlIdx) outData = {TAG_TRL, TS_W'(rdLen)};
    else                          outData = {TAG_SMP, TS_W'(smpMem[rdAddr])};
  end
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             acceptIn,
  input  logic             readyIn,
  input  logic [CNT_W-1:0] rdLen,
  output strobe_t          stb,
  output logic             outValid,
  output logic             outLast,
  output logic             bufFull,
  output logic [OVF_W-1:0] ovfCount
);
  logic               accPrev, capturing;
  logic [CNT_W-1:0]   sampCnt, writeIdx;
  logic [SLOT_AW-1:0] wSlot, rSlot;
  logic [IDX_W-1:0]   rIdx;
  logic [SLOT_AW:0]   evCount;
  logic rise, start, drop, commit, lastWord, adv, pop, smpRoom;

  assign rise     = acceptIn & ~accPrev;
  assign bufFull  = (evCount == (SLOT_AW+1)'(SLOTS));
  assign start    = rise & ~bufFull;
  assign drop     = rise & bufFull;
  assign commit   = capturing & ~acceptIn;
  assign writeIdx = start ? '0 : sampCnt;
  assign smpRoom  = writeIdx < CNT_W'(MAX_SAMP);
  assign outValid = (evCount != '0);
  assign lastWord = (rIdx == IDX_W'(rdLen) + IDX_W'(1));
  assign adv      = outValid & readyIn;
  assign pop      = adv & lastWord;
  assign outLast  = outValid & lastWord;

  always_comb begin
    stb.hdrEn    = start;
    stb.smpEn    = (start | (capturing & acceptIn)) & smpRoom;
    stb.trlEn    = commit;
    stb.wrSlot   = wSlot;
    stb.wrIdx    = writeIdx;
    stb.trlCount = sampCnt;
    stb.rdSlot   = rSlot;
    stb.rdIdx    = rIdx;
  end

  function automatic logic [SLOT_AW-1:0] nextSlot(logic [SLOT_AW-1:0] s);
    return (s == SLOT_AW'(SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accPrev   <= 1'b0;
      capturing <= 1'b0;
      sampCnt   <= '0;
      wSlot     <= '0;
      rSlot     <= '0;
      rIdx      <= '0;
      evCount   <= '0;
      ovfCount  <= '0;
    end else begin
      accPrev <= acceptIn;
      if (start) begin
        capturing <= 1'b1;
        sampCnt   <= CNT_W'(1);
      end else if (commit) begin
        capturing <= 1'b0;
        wSlot     <= nextSlot(wSlot);
      end else if (capturing && acceptIn && smpRoom) begin
        sampCnt <= sampCnt + 1'b1;
      end
      if (adv) begin
        if (lastWord) begin
          rIdx  <= '0;
          rSlot <= nextSlot(rSlot);
        end else begin
          rIdx <= rIdx + 1'b1;
        end
      end
      evCount <= evCount + (SLOT_AW+1)'(commit) - (SLOT_AW+1)'(pop);
      if (drop && ovfCount != '1) ovfCount <= ovfCount + 1'b1;
    end
  end
endmodule

// File: rtl/latency_event_buffer.sv
module latency_event_buffer
  import lbuf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                acceptIn,
  input  logic [TS_W-1:0]     tsIn,
  input  logic                readyIn,
  output logic [WORD_W-1:0]   outData,
  output logic                outValid,
  output logic                outLast,
  output logic                bufFull,
  output logic [OVF_W-1:0]    ovfCount
);
  strobe_t          stb;
  logic [CNT_W-1:0] rdLen;

  lbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .acceptIn(acceptIn), .readyIn(readyIn),
    .rdLen(rdLen), .stb(stb), .outValid(outValid), .outLast(outLast),
    .bufFull(bufFull), .ovfCount(ovfCount)
  );

  lbuf_dpath u_dpath (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .tsIn(tsIn),
    .stb(stb), .rdLen(rdLen), .outData(outData)
  );
endmodule

// File: rtl/lbuf_checker.sv
module lbuf_checker
  import lbuf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              acceptIn,
  input logic              readyIn,
  input logic [WORD_W-1:0] outData,
  input logic              outValid,
  input logic              outLast,
  input logic              bufFull,
  input logic [OVF_W-1:0]  ovfCount
);
  // R9: an offered word stays put until taken
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !readyIn) |=> (outValid && $stable(outData)));

  // R7: a full buffer always has something to offer
  p_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> outValid);

  // R8: overflow count moves only on a gate opening against a full buffer
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfCount != $past(ovfCount)) |-> ($past(bufFull) && $past(acceptIn)
                                       && ovfCount == $past(ovfCount) + 1'b1));

  // R6: an event appears only once the gate has been seen low
  p_hidden_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> !$past(acceptIn));

  // R4: the last-word flag marks a trailer tag
  p_last_tag_r4: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (outValid && outData[WORD_W-1 -: 2] == TAG_TRL));

  // R3: after a trailer is taken, the next offered word is a header
  p_header_next_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && readyIn && outLast) |=> (!outValid || outData[WORD_W-1 -: 2] == TAG_HDR));
endmodule

bind latency_event_buffer lbuf_checker u_chk (
  .clk(clk), .rstN(rstN), .acceptIn(acceptIn), .readyIn(readyIn),
  .outData(outData), .outValid(outValid), .outLast(outLast),
  .bufFull(bufFull), .ovfCount(ovfCount)
);

// File: tb/latency_event_buffer_tb.sv
module latency_event_buffer_tb;
  import lbuf_pkg::*;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [SAMPLE_W-1:0] sampleIn = '0;
  logic                acceptIn = 1'b0;
  logic [TS_W-1:0]     tsIn = '0;
  logic                readyIn = 1'b0;
  logic [WORD_W-1:0]   outData;
  logic                outValid, outLast, bufFull;
  logic [OVF_W-1:0]    ovfCount;

  latency_event_buffer u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .acceptIn(acceptIn),
    .tsIn(tsIn), .readyIn(readyIn), .outData(outData), .outValid(outValid),
    .outLast(outLast), .bufFull(bufFull), .ovfCount(ovfCount)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0, edgeN = 0, expOvf = 0;
  bit done = 1'b0;
  int qStart [16];
  int qLen   [16];
  int qHead = 0, qTail = 0, qCnt = 0;

  always @(posedge clk) edgeN++;

  function automatic logic [SAMPLE_W-1:0] pat(int n);
    return SAMPLE_W'((n * 37 + 5) % (1 << SAMPLE_W));
  endfunction

  // stimulus for the edge that follows this negedge
  always @(negedge clk) begin
    sampleIn <= pat(edgeN + 1);
    tsIn     <= TS_W'(edgeN + 1);
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // gate high for L edges; hideCheck verifies nothing is offered meanwhile
  task automatic window(int L, bit hideCheck);
    @(negedge clk);
    acceptIn = 1'b1;
    if (qCnt < SLOTS) begin
      qStart[qTail] = edgeN + 1;
      qLen[qTail]   = L;
      qTail = (qTail + 1) % 16;
      qCnt++;
    end else begin
      expOvf++;
    end
    for (int i = 1; i < L; i++) begin
      @(negedge clk);
      if (hideCheck) chk(!outValid, "R6 hidden during gate", 32'(outValid), 0);
    end
    @(negedge clk);
    acceptIn = 1'b0;
  endtask

  task automatic drain(int nEv, bit stall);
    int idx = 0, got = 0, guard = 0, it = 0, st, n;
    bit held = 1'b0;
    logic [WORD_W-1:0] prevData = '0, expW;
    bit rdy;
    while (got < nEv && guard < 3000) begin
      @(negedge clk);
      guard++;
      it++;
      if (held) chk(outValid && outData == prevData, "R9 word held while stalled",
                    32'(outData), 32'(prevData));
      rdy = stall ? (it % 3 != 0) : 1'b1;
      readyIn = rdy;
      held = outValid && !rdy;
      prevData = outData;
      if (outValid && rdy) begin
        st = qStart[qHead];
        n  = (qLen[qHead] < MAX_SAMP) ? qLen[qHead] : MAX_SAMP;
        if (idx == 0) begin
          expW = {TAG_HDR, TS_W'(st)};
          chk(outData == expW, "R3 header timestamp", 32'(outData), 32'(expW));
        end else if (idx <= n) begin
          expW = {TAG_SMP, TS_W'(pat(st - DELAY + idx - 1))};
          chk(outData == expW, "R1 delayed sample", 32'(outData), 32'(expW));
        end else begin
          expW = {TAG_TRL, TS_W'(n)};
          chk(outData == expW, (qLen[qHead] > MAX_SAMP) ? "R5 truncated count" : "R2 sample count",
              32'(outData), 32'(expW));
        end
        chk(outLast == (idx == n + 1), "R4 last flag", 32'(outLast), 32'(idx == n + 1));
        if (idx == n + 1) begin
          idx = 0;
          got++;
          qHead = (qHead + 1) % 16;
          qCnt--;
        end else begin
          idx++;
        end
      end
    end
    if (guard >= 3000) chk(1'b0, "R9 drain stuck", 32'(got), 32'(nEv));
    @(negedge clk);
    readyIn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!outValid && !outLast && !bufFull && ovfCount == 0, "R10 reset state",
        {outValid, outLast, bufFull, ovfCount}, 0);
    rstN = 1'b1;
    repeat (200) @(negedge clk);
    chk(!outValid && ovfCount == 0, "R10 idle after reset", 32'(outValid), 0);

    // sweep gate length across the sample limit
    for (int L = 1; L <= 16; L++) begin
      window(L, 1'b1);
      drain(1, L[0]);
      @(negedge clk);
      chk(!outValid, "R9 empty after drain", 32'(outValid), 0);
    end

    // visibility right after the gate closes
    window(5, 1'b1);
    @(negedge clk);
    chk(outValid, "R6 visible after gate closes", 32'(outValid), 1);
    drain(1, 1'b0);

    // fill all slots, then overflow
    for (int k = 0; k < SLOTS; k++) begin
      window(3 + k, 1'b0);
      @(negedge clk);
      chk(bufFull == (k == SLOTS - 1), "R7 full flag", 32'(bufFull), 32'(k == SLOTS - 1));
    end
    window(4, 1'b0);
    @(negedge clk);
    window(6, 1'b0);
    @(negedge clk);
    chk(ovfCount == OVF_W'(expOvf) && expOvf == 2, "R8 overflow count", 32'(ovfCount), 2);
    chk(bufFull, "R7 still full after drops", 32'(bufFull), 1);
    drain(SLOTS, 1'b1);
    @(negedge clk);
    chk(!outValid && !bufFull, "R8 dropped gates left nothing", {outValid, bufFull}, 0);

    // back-to-back gates with a one-edge gap
    window(4, 1'b0);
    window(5, 1'b0);
    drain(2, 1'b0);

    // capture during readout
    window(6, 1'b0);
    fork
      window(10, 1'b0);
      drain(1, 1'b1);
    join
    drain(1, 1'b0);
    @(negedge clk);
    chk(!outValid && ovfCount == 2, "R11 concurrent capture and readout", {outValid, ovfCount}, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule